// File: doc/BRIEF.md
# Fractional-Divide UART Transmitter

This block serialises one byte per request onto an asynchronous serial line. Its bit timing comes from a source clock that need not be an integer multiple of the baud rate. Each bit on the line lasts a whole number of source clocks. That number is a base count plus a 0-or-1 correction bit drawn from an 8-bit modulation pattern. Spreading the extra clocks across the frame keeps the drift of bit edges against the ideal baud grid within a fraction of a bit.

The base count has two modes. In direct mode it is the integer divider itself. In oversampling mode it is sixteen times the divider (acting as a prescaler) plus a 4-bit fine fraction. A user sets the divider fields, presents a byte and pulses the start input while the busy output is low. The block captures everything at that moment and drives one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Busy stays high until the stop bit has run its full length.

Top module: `fracdiv_uart_tx`

## Requirements
- R1: While reset is held and whenever no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: A frame is exactly ten bit periods: a start bit at 0, then `tx_data` bit 0 through bit 7, then a stop bit at 1.
- R3: With `os_en`=0, frame bit i lasts `div_int` + m(i) source clocks.
- R4: With `os_en`=1, frame bit i lasts 16*`div_int` + `div_frac` + m(i) source clocks.
- R5: The correction bit is m(i) = `mod_pat`[7 - (i mod 8)], where i is the frame bit index (0 = start bit, 9 = stop bit). The start bit therefore uses pattern bit 7, the first data bit uses bit 6, frame bit 8 wraps to bit 7 and the stop bit uses bit 6. Every frame begins again at pattern bit 7.
- R6: With `mod_pat` = 0, every bit of the frame lasts exactly the base count.
- R7: A `tx_start` pulse while `busy` is 1 has no effect. `busy` falls in the cycle right after the last stop-bit clock, and no further frame follows unless a new start is given.
- R8: Divider fields, pattern and data are captured when a start is accepted. Changing them during a frame does not alter that frame.
- R9: When `tx_start` is sampled at 1 while idle, both `busy`=1 and `txd`=0 appear after that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for bit timing |
| rst_n | input | 1 | Synchronous reset, active low |
| os_en | input | 1 | 1 selects oversampling divider mode, 0 selects direct mode |
| div_int | input | 12 | Direct divider, or prescaler in oversampling mode |
| div_frac | input | 4 | Fine fraction added to the base count in oversampling mode |
| mod_pat | input | 8 | Modulation pattern, one correction bit per frame bit |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Request to send, accepted only while idle |
| txd | output | 1 | Serial line |
| busy | output | 1 | High from accepted start until the end of the stop bit |

## Verification
The first frame runs in direct mode with divider 13 and pattern 0xB6, so the start bit lasts 14 clocks, the first data bit 13 clocks and the next data bit 14 clocks. A wrong pattern order (LSB first, or a pattern index that does not reset) shows up as a length error on the first bits. The second frame runs in oversampling mode with prescaler 4, fraction 5 and pattern 0x55. Its 69/70/69 rhythm separates the 16x base from the direct base and confirms the fraction is added once per bit.

Single-bit patterns 0x80 and 0x40 place the only extra clock on bit 0 and bit 8, or on bit 1 and the stop bit, which exposes how the pattern index wraps. A zero pattern gives equal bit lengths. Most frames send 0x55, so every bit edge shows on the line and any length error is seen.

One frame receives a start pulse mid-frame together with new divider, pattern and data values, which must change nothing. Two frames sent back to back check that a start given right after busy falls is accepted.

// File: rtl/fracdiv_pkg.sv
// Shared constants and types for the fractional-divide UART transmitter.
// Assumes an oversampling factor that is a power of two.
package fracdiv_pkg;
    localparam int OS_FACTOR = 16;
    localparam int OS_SHIFT  = $clog2(OS_FACTOR);

    typedef enum logic {
        TX_IDLE   = 1'b0,
        TX_ACTIVE = 1'b1
    } tx_state_e;
endpackage

// File: rtl/fd_len_calc.sv
// Bit-length calculator: turns the divider configuration and one correction
// bit into the number of source clocks the current bit lasts.
// Assumes CNT_W is wide enough for OS_FACTOR*max(div_int)+max(div_frac)+1.
module fd_len_calc
    import fracdiv_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = DIV_W + OS_SHIFT + 1
) (
    input  logic              os_en,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              mod_bit,
    output logic [CNT_W-1:0]  bit_len
);
    logic [CNT_W-1:0] base_direct;
    logic [CNT_W-1:0] base_os;

    // Base count for each mode, then the selected base plus the correction.
    always_comb begin
        base_direct = CNT_W'(div_int);
        base_os     = (CNT_W'(div_int) << OS_SHIFT) + CNT_W'(div_frac);
        bit_len     = (os_en ? base_os : base_direct) + CNT_W'(mod_bit);
    end
endmodule

// File: rtl/fd_mod_sel.sv
// Modulation bit selector: picks the correction bit for a frame bit index,
// consuming the pattern from its most significant bit and wrapping after
// MOD_W bits. Assumes MOD_W is a power of two.
module fd_mod_sel #(
    parameter int MOD_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [MOD_W-1:0] mod_pat,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             mod_bit
);
    localparam int POS_W = $clog2(MOD_W);

    logic [MOD_W-1:0] pat_rev;

    // Reverse the pattern so that position 0 is its most significant bit.
    for (genvar g = 0; g < MOD_W; g++) begin : g_rev
        assign pat_rev[g] = mod_pat[MOD_W-1-g];
    end

    // Wrap the frame index onto the pattern width.
    always_comb mod_bit = pat_rev[POS_W'(bit_idx)];
endmodule

// File: rtl/fd_bit_timer.sv
// Bit period timer: loaded with a length in source clocks, it flags the
// last clock of that period. Assumes every loaded length is at least 1.
module fd_bit_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             bit_end
);
    logic [CNT_W-1:0] remain;

    // Count down the clocks left in the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= len - CNT_W'(1);
        else if (run && remain != '0)
            remain <= remain - CNT_W'(1);
    end

    assign bit_end = run && (remain == '0);

    // R3/R4: a zero length would make a bit last 2^CNT_W clocks.
    p_len_nonzero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));
endmodule

// File: rtl/fracdiv_uart_tx.sv
// Fractional-divide UART transmitter top. Captures configuration and data on
// an accepted start, then sends start, data (LSB first) and stop bits, each
// lasting a base count plus one pattern-selected correction clock.
// Assumes the configured bit length is never zero.
module fracdiv_uart_tx
    import fracdiv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter int MOD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_en,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [MOD_W-1:0]  mod_pat,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              txd,
    output logic              busy
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int CNT_W      = DIV_W + OS_SHIFT + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    tx_state_e            state;
    logic [IDX_W-1:0]     bit_idx;
    logic [FRAME_BITS-1:0] shreg;
    logic                 os_q;
    logic [DIV_W-1:0]     div_q;
    logic [FRAC_W-1:0]    frac_q;
    logic [MOD_W-1:0]     pat_q;

    logic                 start_go;
    logic                 last_bit;
    logic                 bit_end;
    logic                 timer_load;
    logic [IDX_W-1:0]     next_idx;
    logic                 sel_os;
    logic [DIV_W-1:0]     sel_div;
    logic [FRAC_W-1:0]    sel_frac;
    logic [MOD_W-1:0]     sel_pat;
    logic                 next_mod;
    logic [CNT_W-1:0]     next_len;

    // Decode acceptance, frame end and the timer reload.
    always_comb begin
        start_go   = (state == TX_IDLE) && tx_start;
        last_bit   = (bit_idx == LAST_IDX);
        timer_load = start_go || (bit_end && !last_bit);
        next_idx   = start_go ? '0 : bit_idx + IDX_W'(1);
    end

    // Use live configuration for the start bit, captured values afterwards.
    always_comb begin
        sel_os   = start_go ? os_en    : os_q;
        sel_div  = start_go ? div_int  : div_q;
        sel_frac = start_go ? div_frac : frac_q;
        sel_pat  = start_go ? mod_pat  : pat_q;
    end

    fd_mod_sel #(
        .MOD_W (MOD_W),
        .IDX_W (IDX_W)
    ) u_mod_sel (
        .mod_pat (sel_pat),
        .bit_idx (next_idx),
        .mod_bit (next_mod)
    );

    fd_len_calc #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W)
    ) u_len_calc (
        .os_en    (sel_os),
        .div_int  (sel_div),
        .div_frac (sel_frac),
        .mod_bit  (next_mod),
        .bit_len  (next_len)
    );

    fd_bit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .load    (timer_load),
        .len     (next_len),
        .bit_end (bit_end)
    );

    // Frame sequencer: capture on start, shift out one bit per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            bit_idx <= '0;
            shreg   <= '1;
            os_q    <= 1'b0;
            div_q   <= '0;
            frac_q  <= '0;
            pat_q   <= '0;
        end else if (start_go) begin
            state   <= TX_ACTIVE;
            bit_idx <= '0;
            shreg   <= {1'b1, tx_data, 1'b0};
            os_q    <= os_en;
            div_q   <= div_int;
            frac_q  <= div_frac;
            pat_q   <= mod_pat;
        end else if (bit_end) begin
            shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
            bit_idx <= bit_idx + IDX_W'(1);
            if (last_bit)
                state <= TX_IDLE;
        end
    end

    assign txd  = shreg[0];
    assign busy = (state == TX_ACTIVE);

    // R1: the line rests high whenever no frame is running.
    p_idle_high_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R9, R2: a frame opens with the line low.
    p_start_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R2: the final bit of a frame is high.
    p_stop_high_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_bit) |-> txd);

    // R7: busy ends only out of the stop bit.
    p_busy_end_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bit_idx) == LAST_IDX));

    // R5: the frame index advances by one, never skips.
    p_idx_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (bit_idx != $past(bit_idx)))
            |-> (bit_idx == $past(bit_idx) + IDX_W'(1)));

    // R8: captured configuration holds for the whole frame.
    p_cfg_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ($stable(pat_q) && $stable(div_q) && $stable(frac_q) && $stable(os_q)));
endmodule

// File: tb/fracdiv_uart_tx_test.sv
// Scoreboard bench: the driver queues expected (level, length) bit items,
// the monitor pops them and compares the line cycle by cycle.
module fracdiv_uart_tx_test;
    localparam int FRAME = 10;

    typedef struct {
        logic  lvl;
        int    len;
        string tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_en = 1'b0;
    logic [11:0] div_int = 12'd13;
    logic [3:0]  div_frac = 4'd0;
    logic [7:0]  mod_pat = 8'h00;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_start = 1'b0;
    logic        txd;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    fracdiv_uart_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_en    (os_en),
        .div_int  (div_int),
        .div_frac (div_frac),
        .mod_pat  (mod_pat),
        .tx_data  (tx_data),
        .tx_start (tx_start),
        .txd      (txd),
        .busy     (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(bit os, int dv, int fr, int pat, int i);
        int base;
        base = os ? 16 * dv + fr : dv;
        return base + ((pat >> (7 - (i % 8))) & 1);
    endfunction

    task automatic send(input bit os, input int dv, input int fr, input int pat,
                        input int data, input string tag, input bit disturb);
        @(negedge clk);
        os_en = os; div_int = 12'(dv); div_frac = 4'(fr);
        mod_pat = 8'(pat); tx_data = 8'(data);
        for (int i = 0; i < FRAME; i++) begin
            exp_item_t it;
            it.lvl = (i == 0) ? 1'b0 : (i == FRAME - 1) ? 1'b1 : 1'((data >> (i - 1)) & 1);
            it.len = exp_len(os, dv, fr, pat, i);
            it.tag = $sformatf("%s frame bit %0d", tag, i);
            exp_q.push_back(it);
        end
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk(busy === 1'b1 && txd === 1'b0, "R9 busy and start bit after accept",
            int'({busy, txd}), 2);
        if (disturb) begin
            repeat (5) @(negedge clk);
            tx_start = 1'b1; div_int = 12'd3; os_en = ~os;
            mod_pat = ~8'(pat); tx_data = ~8'(data); div_frac = 4'd9;
            @(negedge clk);
            tx_start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    // Monitor: compare each line cycle with the queued expectation.
    initial begin
        exp_item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                for (int b = 0; b < FRAME; b++) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 frame without expectation", 1, 0);
                        break;
                    end
                    it = exp_q.pop_front();
                    for (int k = 0; k < it.len; k++) begin
                        if (k > 0 || b > 0) @(negedge clk);
                        chk(txd === it.lvl && busy === 1'b1, it.tag, int'(txd), int'(it.lvl));
                    end
                end
                @(negedge clk);
                chk(busy === 1'b0, "R7 busy falls after stop", int'(busy), 0);
                chk(txd === 1'b1, "R1 line high after frame", int'(txd), 1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(1'b0, "R7 watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tx_start = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(txd === 1'b1 && busy === 1'b0, "R1 reset state", int'({txd, busy}), 2);
        end
        tx_start = 1'b0;
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", int'({txd, busy}), 2);
        end

        send(0, 13, 0, 8'hB6, 8'h55, "R3 R5 direct 13/B6", 0);
        send(1, 4, 5, 8'h55, 8'h55, "R4 R5 oversample 4/5/55", 0);
        send(0, 16, 0, 8'h00, 8'hA5, "R6 R2 zero pattern", 0);
        send(0, 7, 0, 8'h80, 8'h55, "R5 wrap to bit 7", 0);
        send(0, 9, 0, 8'h40, 8'h55, "R5 stop uses bit 6", 0);
        send(1, 1, 3, 8'hFF, 8'h3C, "R4 full pattern", 0);
        send(0, 13, 0, 8'hB6, 8'h96, "R7 R8 start and config ignored mid-frame", 1);
        repeat (30) begin
            @(negedge clk);
            chk(busy === 1'b0 && txd === 1'b1, "R7 no extra frame", int'({busy, txd}), 1);
        end
        send(0, 5, 0, 8'h24, 8'h55, "R7 back-to-back first", 0);
        send(0, 6, 0, 8'hB6, 8'hC3, "R7 R5 back-to-back second", 0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expectations consumed", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule